// File: doc/BRIEF.md
# General-Purpose Event Interrupt Aggregator

This block gathers a parameterised number of hardware event lines into a single shared, level-sensitive system control interrupt. Each event line has two bits:

- a pending bit, which a one-cycle event pulse sets and only software clears, by writing a 1 to that bit;
- a mask-enable bit, which software loads directly.

An event counts as active while its pending bit and its enable bit are both 1. The interrupt line is the OR of all active terms. Because it is a level, it stays high until software has acknowledged every enabled pending event.

Software reaches both registers through a synchronous word-wide write/read port. Address 0 selects the pending register and address 1 selects the enable register. The interrupt level comes from a two-state machine:

- In state `IRQ_QUIET` the output is low. The `RAISE` transition, taken when any active term is seen, moves to `IRQ_RAISED`.
- In state `IRQ_RAISED` the output is high. The `CLEAR` transition, taken when no active term remains, returns to `IRQ_QUIET`.

The usual acknowledge flow is: mask the enable bit, clear the pending bit with a 1, then unmask. If the event fired again in the meantime, the interrupt comes back as soon as the bit is unmasked.

Top module: `gpe_irq_aggregator`

## Requirements
- R1: After reset every pending bit and every enable bit is 0 and `irq_o` is low.
- R2: A 1 on `evt_set_i[i]` at a clock edge sets pending bit i at that edge. The event input never clears a pending bit.
- R3: A write to address 0 clears each pending bit whose data bit is 1. Pending bits whose data bit is 0 keep their value.
- R4: A write to address 1 loads the enable register with the written word exactly, so each 0 masks and each 1 enables.
- R5: `irq_o` is registered. At each clock edge it takes the OR over all i of (pending[i] AND enable[i]) as they stood before that edge, so it follows a change one clock later.
- R6: `irq_o` stays high for as long as any enabled pending bit remains, and it falls only after every pending-AND-enable term is 0. It is never a single-cycle pulse while an active term persists.
- R7: When an event pulse and a write-1-clear hit the same bit at the same edge, the pending bit ends at 1.
- R8: In the sequence mask, clear, unmask, `irq_o` is low after the clear. If the event fired again before the unmask, `irq_o` is high one clock after the enable bit is set again.
- R9: Events that arrive on different lines in back-to-back cycles, including while `irq_o` is already high, are each latched into their own pending bit.
- R10: A read (`rd_en_i`=1) captures into `rd_data_o` at the clock edge the pending word (address 0) or the enable word (address 1) as it was before that edge. `rd_data_o` holds its value when no read is made.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| evt_set_i | input | N | One-cycle event set pulses, one per event line |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe |
| addr_i | input | 1 | Register select: 0 pending, 1 enable |
| wr_data_i | input | N | Write data word |
| rd_data_o | output | N | Registered read data |
| irq_o | output | 1 | Shared level interrupt |

## Verification
An event pulse and a software write-1-clear can reach the same pending bit in the same cycle. The bench provokes this in directed cases and also lets random traffic overlap random event pulses with random clear masks. The reference model applies the clear first and the set second, so any dropped event shows up both in the pending readback and in the interrupt level that follows it. The second pair that can coincide is a re-enable and a new arrival during the acknowledge sequence. The bench judges that pair by when the interrupt returns.

// File: rtl/gpe_agg_pkg.sv
package gpe_agg_pkg;

    typedef enum logic {
        REG_PENDING = 1'b0,
        REG_ENABLE  = 1'b1
    } reg_sel_e;

    typedef enum logic {
        IRQ_QUIET  = 1'b0,
        IRQ_RAISED = 1'b1
    } irq_state_e;

endpackage

// File: rtl/evt_pending_bank.sv
module evt_pending_bank #(
    parameter int N = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] evt_set_i,
    input  logic         clr_stb_i,
    input  logic [N-1:0] clr_mask_i,
    output logic [N-1:0] pend_o
);

    logic [N-1:0] pend_q;

    for (genvar g = 0; g < N; g++) begin : g_bit
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                pend_q[g] <= 1'b0;
            end else if (evt_set_i[g]) begin
                pend_q[g] <= 1'b1;
            end else if (clr_stb_i && clr_mask_i[g]) begin
                pend_q[g] <= 1'b0;
            end
        end
    end

    assign pend_o = pend_q;

    // R2 / R7 / R9: every pulsed line is pending after the edge
    p_set_latched_r7: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((pend_q & $past(evt_set_i)) == $past(evt_set_i)));

    // R3: a bit only falls where a clear strobe carried a 1
    p_clear_only_w1_r3: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((($past(pend_q) & ~pend_q) &
                   ~($past(clr_stb_i) ? $past(clr_mask_i) : {N{1'b0}})) == '0));

endmodule

// File: rtl/evt_enable_bank.sv
module evt_enable_bank #(
    parameter int N = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_i,
    input  logic [N-1:0] load_data_i,
    output logic [N-1:0] en_o
);

    logic [N-1:0] en_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q <= '0;
        end else if (load_i) begin
            en_q <= load_data_i;
        end
    end

    assign en_o = en_q;

    // R4: enable takes the written word exactly
    p_enable_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> (en_q == $past(load_data_i)));

    p_enable_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !load_i |=> $stable(en_q));

endmodule

// File: rtl/irq_level_fsm.sv
module irq_level_fsm
    import gpe_agg_pkg::*;
#(
    parameter int N = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] pend_i,
    input  logic [N-1:0] en_i,
    output logic         irq_o
);

    irq_state_e state_q, state_d;
    logic       any_active;

    assign any_active = |(pend_i & en_i);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            IRQ_QUIET:  if (any_active)  state_d = IRQ_RAISED; // RAISE
            IRQ_RAISED: if (!any_active) state_d = IRQ_QUIET;  // CLEAR
            default:    state_d = IRQ_QUIET;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= IRQ_QUIET;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        unique case (state_q)
            IRQ_RAISED: irq_o = 1'b1;
            default:    irq_o = 1'b0;
        endcase
    end

    // R5: output follows the active terms one clock later
    p_irq_follows_r5: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (irq_o == $past(|(pend_i & en_i))));

    // R6: a persisting active term keeps the line high
    p_irq_level_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_o && (|(pend_i & en_i))) |=> irq_o);

endmodule

// File: rtl/gpe_irq_aggregator.sv
module gpe_irq_aggregator
    import gpe_agg_pkg::*;
#(
    parameter int N = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] evt_set_i,
    input  logic         wr_en_i,
    input  logic         rd_en_i,
    input  logic         addr_i,
    input  logic [N-1:0] wr_data_i,
    output logic [N-1:0] rd_data_o,
    output logic         irq_o
);

    logic [N-1:0] pend_w, en_w, rd_q;
    logic         wr_pend, wr_en_reg;

    assign wr_pend   = wr_en_i && (reg_sel_e'(addr_i) == REG_PENDING);
    assign wr_en_reg = wr_en_i && (reg_sel_e'(addr_i) == REG_ENABLE);

    evt_pending_bank #(.N(N)) u_pend (
        .clk        (clk),
        .rst_n      (rst_n),
        .evt_set_i  (evt_set_i),
        .clr_stb_i  (wr_pend),
        .clr_mask_i (wr_data_i),
        .pend_o     (pend_w)
    );

    evt_enable_bank #(.N(N)) u_en (
        .clk         (clk),
        .rst_n       (rst_n),
        .load_i      (wr_en_reg),
        .load_data_i (wr_data_i),
        .en_o        (en_w)
    );

    irq_level_fsm #(.N(N)) u_irq (
        .clk    (clk),
        .rst_n  (rst_n),
        .pend_i (pend_w),
        .en_i   (en_w),
        .irq_o  (irq_o)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_q <= '0;
        end else if (rd_en_i) begin
            rd_q <= (reg_sel_e'(addr_i) == REG_ENABLE) ? en_w : pend_w;
        end
    end

    assign rd_data_o = rd_q;

    // R10: read data holds without a read strobe
    p_rd_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en_i |=> $stable(rd_data_o));

    // R1: quiet registers give a quiet line
    p_quiet_after_reset_r1: assert property (@(posedge clk) disable iff (!rst_n)
        ((pend_w & en_w) == '0) |=> !irq_o);

endmodule

// File: tb/gpe_irq_aggregator_tb_top.sv
`timescale 1ns/1ps
module gpe_irq_aggregator_tb_top;

    localparam int N = 16;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [N-1:0] evt_set_i = '0;
    logic         wr_en_i = 1'b0;
    logic         rd_en_i = 1'b0;
    logic         addr_i = 1'b0;
    logic [N-1:0] wr_data_i = '0;
    logic [N-1:0] rd_data_o;
    logic         irq_o;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    logic [N-1:0] pend_m = '0;
    logic [N-1:0] en_m   = '0;

    always #2 clk = ~clk;

    gpe_irq_aggregator #(.N(N)) dut_i (
        .clk(clk), .rst_n(rst_n), .evt_set_i(evt_set_i), .wr_en_i(wr_en_i),
        .rd_en_i(rd_en_i), .addr_i(addr_i), .wr_data_i(wr_data_i),
        .rd_data_o(rd_data_o), .irq_o(irq_o)
    );

    function automatic logic model_irq(logic [N-1:0] p, logic [N-1:0] e);
        return |(p & e);
    endfunction

    task automatic expect_val(string tag, logic [N-1:0] act, logic [N-1:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Called at a negedge: drive, take one edge, update model, check at next negedge.
    task automatic step(logic [N-1:0] evt, logic wr, logic rd, logic a,
                        logic [N-1:0] d, string rtag);
        logic         irq_exp;
        logic [N-1:0] rd_exp;
        evt_set_i = evt; wr_en_i = wr; rd_en_i = rd; addr_i = a; wr_data_i = d;
        @(posedge clk);
        irq_exp = model_irq(pend_m, en_m);
        rd_exp  = a ? en_m : pend_m;
        if (wr && !a) pend_m = pend_m & ~d;
        pend_m = pend_m | evt;
        if (wr && a) en_m = d;
        @(negedge clk);
        expect_val("R5", {{(N-1){1'b0}}, irq_o}, {{(N-1){1'b0}}, irq_exp});
        if (rd) expect_val(rtag, rd_data_o, rd_exp);
        evt_set_i = '0; wr_en_i = 1'b0; rd_en_i = 1'b0;
    endtask

    task automatic idle();
        step('0, 1'b0, 1'b0, 1'b0, '0, "R5");
    endtask

    task automatic rd_pend(string tag);  step('0, 1'b0, 1'b1, 1'b0, '0, tag); endtask
    task automatic rd_en(string tag);    step('0, 1'b0, 1'b1, 1'b1, '0, tag); endtask
    task automatic clr_pend(logic [N-1:0] d); step('0, 1'b1, 1'b0, 1'b0, d, "R3"); endtask
    task automatic set_en(logic [N-1:0] d);   step('0, 1'b1, 1'b0, 1'b1, d, "R4"); endtask

    initial begin
        #(4 * 100000);
        if (!done) begin
            n_checks++; n_fails++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'hC0FFEE));
        repeat (3) @(negedge clk);
        expect_val("R1", {{(N-1){1'b0}}, irq_o}, '0);
        rst_n = 1'b1;
        @(negedge clk);
        rd_pend("R1"); expect_val("R1", rd_data_o, '0);
        rd_en("R1");   expect_val("R1", rd_data_o, '0);
        expect_val("R1", {{(N-1){1'b0}}, irq_o}, '0);

        // R2: event sets pending, stays after pulse ends
        step(16'h0008, 1'b0, 1'b0, 1'b0, '0, "R2");
        idle();
        rd_pend("R2"); expect_val("R2", rd_data_o, 16'h0008);
        expect_val("R2", {{(N-1){1'b0}}, irq_o}, '0);

        // R4/R5: enabling raises irq one clock later
        set_en(16'h0008);
        expect_val("R5", {{(N-1){1'b0}}, irq_o}, '0);
        idle();
        expect_val("R5", {{(N-1){1'b0}}, irq_o}, 16'h1);
        rd_en("R4"); expect_val("R4", rd_data_o, 16'h0008);

        // R3: writing 0 keeps the bit
        clr_pend(16'hFFF7);
        rd_pend("R3"); expect_val("R3", rd_data_o, 16'h0008);
        expect_val("R3", {{(N-1){1'b0}}, irq_o}, 16'h1);

        // R6: two active terms, clear one, line stays; clear the other, line drops
        step(16'h0100, 1'b0, 1'b0, 1'b0, '0, "R9");
        set_en(16'h0108);
        clr_pend(16'h0008);
        idle();
        expect_val("R6", {{(N-1){1'b0}}, irq_o}, 16'h1);
        clr_pend(16'h0100);
        idle();
        expect_val("R6", {{(N-1){1'b0}}, irq_o}, '0);

        // R7: set and clear on the same bit at the same edge
        step(16'h0020, 1'b0, 1'b0, 1'b0, '0, "R2");
        step(16'h0020, 1'b1, 1'b0, 1'b0, 16'h0020, "R7");
        rd_pend("R7"); expect_val("R7", rd_data_o, 16'h0020);
        clr_pend(16'h0020);
        rd_pend("R3"); expect_val("R3", rd_data_o, 16'h0000);

        // R8: mask, clear, new event, unmask -> irq returns
        set_en(16'h0040);
        step(16'h0040, 1'b0, 1'b0, 1'b0, '0, "R2");
        idle();
        expect_val("R8", {{(N-1){1'b0}}, irq_o}, 16'h1);
        set_en(16'h0000);
        clr_pend(16'h0040);
        idle();
        expect_val("R8", {{(N-1){1'b0}}, irq_o}, '0);
        step(16'h0040, 1'b0, 1'b0, 1'b0, '0, "R2");
        set_en(16'h0040);
        idle();
        expect_val("R8", {{(N-1){1'b0}}, irq_o}, 16'h1);

        // R9: burst while irq high
        step(16'h0001, 1'b0, 1'b0, 1'b0, '0, "R9");
        step(16'h0002, 1'b0, 1'b0, 1'b0, '0, "R9");
        step(16'h8000, 1'b0, 1'b0, 1'b0, '0, "R9");
        rd_pend("R9"); expect_val("R9", rd_data_o, 16'h8043);
        expect_val("R9", {{(N-1){1'b0}}, irq_o}, 16'h1);
        clr_pend(16'hFFFF);
        set_en(16'h0000);

        // R10: read data holds across idle cycles
        rd_en("R10");
        idle(); idle();
        expect_val("R10", rd_data_o, 16'h0000);

        // Random traffic against the model
        for (int k = 0; k < 3000; k++) begin
            logic [N-1:0] ev, dt;
            logic wr, rd, a;
            ev = N'($urandom & $urandom & $urandom);
            dt = N'($urandom);
            wr = ($urandom % 3) == 0;
            rd = ($urandom % 2) == 0;
            a  = 1'($urandom);
            step(ev, wr, rd, a, dt, "R10");
        end

        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

endmodule